// File: doc/BRIEF.md
# Blind Constant-Modulus Adaptive Equalizer

This block is a complex-valued adaptive FIR equalizer that needs no training sequence. It accepts one I/Q sample per symbol, filters it through a transposed-form complex FIR, and returns one equalized I/Q sample per accepted input. After each output, it measures how far the squared output magnitude is from a modulus constant. It then moves every tap weight along the negative gradient: the error times the conjugate of the input sample that the tap saw.

The block sits after gain control and ahead of carrier recovery and symbol decisions. Its defaults suit QPSK at one sample per symbol with 18 complex taps.

Both sides of the stream use valid/ready. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. The output register is loaded on each acceptance. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input directly. While `out_valid` is high and `out_ready` is low, the output data holds. Only accepted samples advance the filter and the weights. Idle cycles and stalls leave all state untouched.

Top module: `cma_equalizer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and both output words are 0. Tap CTR = NTAPS/2 (tap 9 by default) holds weight 1.0 (value 2^W_FRAC = 16384). Every other tap holds 0.
- R2: `in_ready` equals `!out_valid || out_ready`. Each accepted input makes `out_valid` high on the next edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` stay unchanged.
- R3: Inputs whose squared modulus, floored to the Q.10 format, equals CMOD give zero error and leave the weights at their reset values. With the default CMOD = 1023, QPSK points at ±724 ± j724 are such inputs. In that case output n equals input n−9 exactly, and the first 9 outputs are 0.
- R4: Samples and outputs are signed Q.10 (value/1024); weights are signed 18-bit Q.14. On acceptance of x(n), tap k forms the complex product w_k·x(n) with the weights currently held and adds the sum registered by tap k+1 at the previous acceptance (zero for the last tap). The result is saturated to ACC_W = 32 bits. Tap 0's sum, shifted right arithmetically by 14 and saturated to 16 bits, is y(n).
- R5: The error of output y is computed in three steps. First, d = sat18(CMOD − ((yR² + yI²) >>> 10)). Then eR = sat16((yR·d) >>> 10) and eI = sat16((yI·d) >>> 10).
- R6: On each acceptance after the first since reset, every tap k updates from the error e of the previous output and from x_k, the input accepted k samples before that output's input. The update is wR += (eR·xR + eI·xI) >>> 12 and wI += (eI·xR − eR·xI) >>> 12, where 12 is the step-size shift of 6 plus the format alignment. Each result is saturated to 18 bits. Weights used in a product are those held before that edge's update.
- R7: Every sum, output and weight saturates to its width instead of wrapping, including under full-scale inputs.
- R8: Cycles without acceptance change no weight, no partial sum and no output word. The output sequence depends only on the accepted sample sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_re | input | X_W (12) | Input in-phase sample, signed Q.10 |
| in_im | input | X_W (12) | Input quadrature sample, signed Q.10 |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_re | output | Y_W (16) | Equalized in-phase sample, signed Q.10 |
| out_im | output | Y_W (16) | Equalized quadrature sample, signed Q.10 |

## Verification
A wrong error value or a misaligned conjugate product corrupts the weights on the next acceptance. That shows on the output at once through tap 0 and the center tap. Over later samples it also leaks in through the partial-sum chain. A wrong partial sum shows at the output within at most NTAPS accepted samples, as it walks the chain. Because of this, every accepted output is compared with a bit-exact model of the stated arithmetic, with stalls and bubbles mixed in. That catches any divergence within one sample of where it reaches tap 0.

// File: rtl/cma_pkg.sv
package cma_pkg;
  // Clamp a signed value to the range of a w-bit two's-complement word.
  function automatic longint sat_w(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/cma_fir.sv
module cma_fir
  import cma_pkg::*;
#(
  parameter int NTAPS  = 18,
  parameter int X_W    = 12,
  parameter int W_W    = 18,
  parameter int W_FRAC = 14,
  parameter int ACC_W  = 32,
  parameter int Y_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic signed [X_W-1:0]   x_re,
  input  logic signed [X_W-1:0]   x_im,
  input  logic signed [W_W-1:0]   w_re [NTAPS],
  input  logic signed [W_W-1:0]   w_im [NTAPS],
  output logic signed [Y_W-1:0]   y_re,
  output logic signed [Y_W-1:0]   y_im
);
  logic signed [ACC_W-1:0] p_re [NTAPS];
  logic signed [ACC_W-1:0] p_im [NTAPS];
  logic signed [ACC_W-1:0] s_re [NTAPS-1];
  logic signed [ACC_W-1:0] s_im [NTAPS-1];

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [ACC_W-1:0] add_re;
    logic signed [ACC_W-1:0] add_im;
    if (k == NTAPS - 1) begin : g_last
      assign add_re = '0;
      assign add_im = '0;
    end else begin : g_mid
      assign add_re = s_re[k];
      assign add_im = s_im[k];
    end
    assign p_re[k] = ACC_W'(sat_w(longint'(x_re) * longint'(w_re[k])
                                  - longint'(x_im) * longint'(w_im[k])
                                  + longint'(add_re), ACC_W));
    assign p_im[k] = ACC_W'(sat_w(longint'(x_re) * longint'(w_im[k])
                                  + longint'(x_im) * longint'(w_re[k])
                                  + longint'(add_im), ACC_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS - 1; k++) begin
        s_re[k] <= '0;
        s_im[k] <= '0;
      end
    end else if (shift_en) begin
      for (int k = 0; k < NTAPS - 1; k++) begin
        s_re[k] <= p_re[k+1];
        s_im[k] <= p_im[k+1];
      end
    end
  end

  assign y_re = Y_W'(sat_w(longint'(p_re[0]) >>> W_FRAC, Y_W));
  assign y_im = Y_W'(sat_w(longint'(p_im[0]) >>> W_FRAC, Y_W));

  // R8: partial sums move only on an accepted sample
  p_chain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(s_re[0]) && $stable(s_im[0])));
endmodule

// File: rtl/cma_err.sv
module cma_err
  import cma_pkg::*;
#(
  parameter int Y_W  = 16,
  parameter int E_W  = 16,
  parameter int D_W  = 18,
  parameter int FRAC = 10,
  parameter int CMOD = 1023
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [Y_W-1:0] y_re,
  input  logic signed [Y_W-1:0] y_im,
  output logic signed [E_W-1:0] e_re,
  output logic signed [E_W-1:0] e_im
);
  logic signed [D_W-1:0] dev;

  assign dev = D_W'(sat_w(longint'(CMOD)
                          - ((longint'(y_re) * longint'(y_re)
                              + longint'(y_im) * longint'(y_im)) >>> FRAC), D_W));
  assign e_re = E_W'(sat_w((longint'(y_re) * longint'(dev)) >>> FRAC, E_W));
  assign e_im = E_W'(sat_w((longint'(y_im) * longint'(dev)) >>> FRAC, E_W));

  // R5: a zero output carries no error
  p_zero_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (y_re == '0 && y_im == '0) |-> (e_re == '0 && e_im == '0));
endmodule

// File: rtl/cma_tap_upd.sv
module cma_tap_upd
  import cma_pkg::*;
#(
  parameter int NTAPS     = 18,
  parameter int X_W       = 12,
  parameter int W_W       = 18,
  parameter int W_FRAC    = 14,
  parameter int E_W       = 16,
  parameter int UPD_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic signed [E_W-1:0] e_re,
  input  logic signed [E_W-1:0] e_im,
  input  logic signed [X_W-1:0] xd_re [NTAPS],
  input  logic signed [X_W-1:0] xd_im [NTAPS],
  output logic signed [W_W-1:0] w_re  [NTAPS],
  output logic signed [W_W-1:0] w_im  [NTAPS]
);
  localparam int CTR = NTAPS / 2;

  for (genvar k = 0; k < NTAPS; k++) begin : g_w
    localparam logic signed [W_W-1:0] RST_RE =
      (k == CTR) ? W_W'(longint'(1) <<< W_FRAC) : '0;
    logic signed [W_W-1:0] nxt_re;
    logic signed [W_W-1:0] nxt_im;

    assign nxt_re = W_W'(sat_w(longint'(w_re[k])
                     + ((longint'(e_re) * longint'(xd_re[k])
                         + longint'(e_im) * longint'(xd_im[k])) >>> UPD_SHIFT), W_W));
    assign nxt_im = W_W'(sat_w(longint'(w_im[k])
                     + ((longint'(e_im) * longint'(xd_re[k])
                         - longint'(e_re) * longint'(xd_im[k])) >>> UPD_SHIFT), W_W));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w_re[k] <= RST_RE;
        w_im[k] <= '0;
      end else if (upd_en) begin
        w_re[k] <= nxt_re;
        w_im[k] <= nxt_im;
      end
    end

    // R8: weights frozen on cycles without an update
    p_w_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> ($stable(w_re[k]) && $stable(w_im[k])));
  end
endmodule

// File: rtl/cma_equalizer.sv
module cma_equalizer
  import cma_pkg::*;
#(
  parameter int NTAPS    = 18,
  parameter int X_W      = 12,
  parameter int FRAC     = 10,
  parameter int W_W      = 18,
  parameter int W_FRAC   = 14,
  parameter int ACC_W    = 32,
  parameter int Y_W      = 16,
  parameter int E_W      = 16,
  parameter int D_W      = 18,
  parameter int MU_SHIFT = 6,
  parameter int CMOD     = 1023
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic signed [X_W-1:0] in_re,
  input  logic signed [X_W-1:0] in_im,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic signed [Y_W-1:0] out_re,
  output logic signed [Y_W-1:0] out_im
);
  localparam int UPD_SHIFT = MU_SHIFT + 2 * FRAC - W_FRAC;

  logic                  accept;
  logic                  have_err;
  logic signed [X_W-1:0] xd_re [NTAPS];
  logic signed [X_W-1:0] xd_im [NTAPS];
  logic signed [W_W-1:0] w_re  [NTAPS];
  logic signed [W_W-1:0] w_im  [NTAPS];
  logic signed [Y_W-1:0] y_re, y_im;
  logic signed [E_W-1:0] e_re, e_im;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // Input history: after acceptance of x(n), xd[k] holds x(n-k).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin
        xd_re[k] <= '0;
        xd_im[k] <= '0;
      end
    end else if (accept) begin
      xd_re[0] <= in_re;
      xd_im[0] <= in_im;
      for (int k = 1; k < NTAPS; k++) begin
        xd_re[k] <= xd_re[k-1];
        xd_im[k] <= xd_im[k-1];
      end
    end
  end

  cma_fir #(
    .NTAPS(NTAPS), .X_W(X_W), .W_W(W_W), .W_FRAC(W_FRAC),
    .ACC_W(ACC_W), .Y_W(Y_W)
  ) u_fir (
    .clk(clk), .rst_n(rst_n), .shift_en(accept),
    .x_re(in_re), .x_im(in_im), .w_re(w_re), .w_im(w_im),
    .y_re(y_re), .y_im(y_im)
  );

  // Output register doubles as the filter/error pipeline boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      have_err  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_re    <= y_re;
        out_im    <= y_im;
        have_err  <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  cma_err #(
    .Y_W(Y_W), .E_W(E_W), .D_W(D_W), .FRAC(FRAC), .CMOD(CMOD)
  ) u_err (
    .clk(clk), .rst_n(rst_n), .y_re(out_re), .y_im(out_im),
    .e_re(e_re), .e_im(e_im)
  );

  cma_tap_upd #(
    .NTAPS(NTAPS), .X_W(X_W), .W_W(W_W), .W_FRAC(W_FRAC),
    .E_W(E_W), .UPD_SHIFT(UPD_SHIFT)
  ) u_upd (
    .clk(clk), .rst_n(rst_n), .upd_en(accept && have_err),
    .e_re(e_re), .e_im(e_im), .xd_re(xd_re), .xd_im(xd_im),
    .w_re(w_re), .w_im(w_im)
  );

  // R2: output held under back-pressure
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));
  // R2: an accepted input yields a pending output
  p_accept_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R8: output words change only after an acceptance
  p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(out_re) && $stable(out_im)));
endmodule

// File: tb/cma_equalizer_bench.sv
module cma_equalizer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 18;
  localparam int CT = NT / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [11:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_re, out_im;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cma_equalizer u_cma_equalizer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  // Reference model state, built from the requirements.
  longint m_wr[NT], m_wi[NT], m_sr[NT], m_si[NT], m_xr[NT], m_xi[NT];
  longint m_yr, m_yi;
  bit     m_prev;
  longint q_re[$], q_im[$];
  longint sent_re[$], sent_im[$];

  function automatic longint clamp(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < NT; k++) begin
      m_wr[k] = (k == CT) ? 16384 : 0;
      m_wi[k] = 0; m_sr[k] = 0; m_si[k] = 0; m_xr[k] = 0; m_xi[k] = 0;
    end
    m_yr = 0; m_yi = 0; m_prev = 0;
    q_re.delete(); q_im.delete(); sent_re.delete(); sent_im.delete();
  endfunction

  function automatic void model_step(longint xr, longint xi);
    longint pr[NT], pim[NT];
    longint d, er, ei, yr, yi;
    for (int k = 0; k < NT; k++) begin
      longint ar = (k == NT - 1) ? 0 : m_sr[k];
      longint ai = (k == NT - 1) ? 0 : m_si[k];
      pr[k]  = clamp(xr * m_wr[k] - xi * m_wi[k] + ar, 32);
      pim[k] = clamp(xr * m_wi[k] + xi * m_wr[k] + ai, 32);
    end
    for (int k = 0; k < NT - 1; k++) begin
      m_sr[k] = pr[k+1]; m_si[k] = pim[k+1];
    end
    yr = clamp(pr[0] >>> 14, 16);
    yi = clamp(pim[0] >>> 14, 16);
    if (m_prev) begin
      d  = clamp(1023 - ((m_yr * m_yr + m_yi * m_yi) >>> 10), 18);
      er = clamp((m_yr * d) >>> 10, 16);
      ei = clamp((m_yi * d) >>> 10, 16);
      for (int k = 0; k < NT; k++) begin
        longint gr = er * m_xr[k] + ei * m_xi[k];
        longint gi = ei * m_xr[k] - er * m_xi[k];
        m_wr[k] = clamp(m_wr[k] + (gr >>> 12), 18);
        m_wi[k] = clamp(m_wi[k] + (gi >>> 12), 18);
      end
    end
    for (int k = NT - 1; k > 0; k--) begin
      m_xr[k] = m_xr[k-1]; m_xi[k] = m_xi[k-1];
    end
    m_xr[0] = xr; m_xi[0] = xi;
    m_yr = yr; m_yi = yi; m_prev = 1;
    q_re.push_back(yr); q_im.push_back(yi);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    check(out_re == 0 && out_im == 0, "R1", "output word after reset", longint'(out_re), 0);
  endtask

  // mode 0: QPSK +-724, 1: moderate random, 2: full scale random
  task automatic run_phase(int nsamp, int pv, int pr, int mode, string req);
    int  nsent = 0, got = 0;
    bit  pending = 0, hold_chk = 0;
    longint hr = 0, hi = 0;
    while (got < nsamp) begin
      @(negedge clk);
      if (!pending && nsent < nsamp && int'($urandom % 100) < pv) begin
        case (mode)
          0: begin
            in_re = ($urandom % 2) ? 12'sd724 : -12'sd724;
            in_im = ($urandom % 2) ? 12'sd724 : -12'sd724;
          end
          1: begin
            in_re = 12'(int'($urandom % 1801) - 900);
            in_im = 12'(int'($urandom % 1801) - 900);
          end
          default: begin
            in_re = 12'(int'($urandom % 4096) - 2048);
            in_im = 12'(int'($urandom % 4096) - 2048);
          end
        endcase
        pending = 1;
      end
      in_valid  = pending;
      out_ready = (int'($urandom % 100) < pr);
      #1;
      if (hold_chk) begin
        check(out_valid && out_re == hr && out_im == hi, "R2",
              "output held under back-pressure", longint'(out_re), hr);
      end
      hold_chk = out_valid && !out_ready;
      hr = out_re; hi = out_im;
      check(in_ready == (!out_valid || out_ready), "R2", "in_ready rule",
            longint'(in_ready), longint'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q_re.size() == 0) begin
          check(0, req, "unexpected output", longint'(out_re), 0);
        end else begin
          longint er = q_re.pop_front();
          longint ei = q_im.pop_front();
          check(out_re == er, req, "out_re vs model", longint'(out_re), er);
          check(out_im == ei, req, "out_im vs model", longint'(out_im), ei);
          if (mode == 0) begin
            longint pr_ = (got >= CT) ? sent_re[got - CT] : 0;
            longint pi_ = (got >= CT) ? sent_im[got - CT] : 0;
            check(out_re == pr_ && out_im == pi_, "R3", "pass-through delay",
                  longint'(out_re), pr_);
          end
        end
        got++;
      end
      if (in_valid && in_ready) begin
        sent_re.push_back(longint'(in_re));
        sent_im.push_back(longint'(in_im));
        model_step(longint'(in_re), longint'(in_im));
        pending = 0;
        nsent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    run_phase(40, 100, 100, 0, "R3");
    do_reset();
    run_phase(300, 70, 70, 1, "R4 R5 R6 R8");
    do_reset();
    run_phase(200, 90, 80, 2, "R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule